// File: doc/BRIEF.md
# Interrupt Aggregator with Set/Clear Control Words

This block gathers six peripheral interrupt sources into one level-sensitive interrupt line for a host processor. Each source gives a single-cycle pulse, and the block holds it in a pending flag. A per-source enable mask gates the pending flags. The gated flags are ORed together and registered to form the processor interrupt.

The host reaches the block through a simple word-register bus. The bus carries a byte address, a write enable, write data and combinational read data. There are four words: a control word, a read-only build identifier, a read-only pending word and an enable-mask word.

For the control and mask words, a write is not a plain store. Each bit of state is driven by a pair of strobe bits, one to set it and one to clear it. A strobe written as 0 does nothing. A read returns the state in a compact layout. The sixth source has no acknowledge pin. Its pending flag is cleared by a strobe bit in the control word.

Top module: `irq_agg_top`

## Requirements
- R1: After reset the control, pending and mask words read 0 and `irq_o` is 0. The identifier word reads `VERSION_WORD` (default 32'h0202_0102).
- R2: Byte offset 0x4 always reads `VERSION_WORD`, and writes to it change nothing.
- R3: A pulse on `src_set[i]` sets pending flag i. A pulse on `src_ack[i]` (i = 0..4) clears flag i. When both arrive in the same cycle, the flag ends up set.
- R4: Pending flag 5 has no acknowledge input. It is cleared by writing offset 0x0 with bit 11 = 1. A set pulse in the same cycle wins over that clear.
- R5: Offset 0x8 returns the pending flags in bits 5:0, with source i at bit i. Bits 31:6 read 0. Writes to offset 0x8 change nothing.
- R6: A write to offset 0xC works per source i. A 1 in bit 2i+1 sets enable i, and a 1 in bit 2i clears it. Reading offset 0xC returns the enables in bits 5:0, with zeros above.
- R7: In any set/clear pair, a strobe written as 0 has no effect. If both strobes of a pair are 1 in the same write, the bit keeps its old value.
- R8: Every write to offset 0x0 loads bits 6:0 into the 7-bit length field. Reading offset 0x0 returns that field in bits 6:0.
- R9: A write to offset 0x0 drives three flag pairs: flag A is cleared by bit 7 and set by bit 8, flag B is cleared by bit 9 and set by bit 10, and flag C is cleared by bit 12 and set by bit 13. A read of offset 0x0 returns A in bit 7, B in bit 8 and C in bit 9, with bits 31:10 reading 0.
- R10: `irq_o` equals the OR over (pending AND enable) as it stood before the previous rising clock edge. It changes one cycle after the state that feeds it.
- R11: An address other than 0x0, 0x4, 0x8 or 0xC reads 0, and a write to it changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_addr | input | ADDR_W | Byte address of the register access |
| reg_we | input | 1 | Write strobe for one cycle |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for `reg_addr` |
| src_set | input | 6 | Per-source interrupt pulses |
| src_ack | input | 5 | Acknowledge pulses for sources 0 to 4 |
| irq_o | output | 1 | Registered interrupt line to the processor |

## Verification
The mask word is driven with all 4096 strobe patterns over bits 11:0 in sequence. This separates the set, clear, ignore-zero and both-ones-hold cases for every pair in every prior state. The control word is swept over all 128 strobe combinations of bits 13:7, each with a different length value, which exposes swapped or misplaced pair bits and any failure to load the length field. The pending flags are driven with every combination of set and acknowledge pulses under two enable masks. The interrupt line is compared after each step with the one-cycle-delayed gated OR, which separates set-wins priority from clear-wins and shows any missing or extra register stage. Writes to unmapped and read-only offsets with all ones, followed by reads of every mapped word, show whether any state leaks.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int unsigned NUM_SRC = 6;
  localparam int unsigned NUM_ACK = NUM_SRC - 1;
  localparam int unsigned DATA_W  = 32;
  localparam int unsigned LEN_W   = 7;
  localparam int unsigned NUM_FLG = 3;

  // word index inside the four-word window
  localparam logic [1:0] IDX_CTRL = 2'd0;
  localparam logic [1:0] IDX_VER  = 2'd1;
  localparam logic [1:0] IDX_PEND = 2'd2;
  localparam logic [1:0] IDX_MASK = 2'd3;

  // control word strobe positions
  localparam int unsigned CTL_A_CLR  = 7;
  localparam int unsigned CTL_A_SET  = 8;
  localparam int unsigned CTL_B_CLR  = 9;
  localparam int unsigned CTL_B_SET  = 10;
  localparam int unsigned CTL_P5_CLR = 11;
  localparam int unsigned CTL_C_CLR  = 12;
  localparam int unsigned CTL_C_SET  = 13;

  typedef struct packed {
    logic flg_c;
    logic flg_b;
    logic flg_a;
    logic [LEN_W-1:0] len;
  } ctrl_view_t;
endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  generate
    if (STAGES == 1) begin : g_one
      assign sh_d = 1'b1;
    end else begin : g_many
      assign sh_d = {sh_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rst_sync_n = sh_q[STAGES-1];
endmodule

// File: rtl/irq_setclr.sv
module irq_setclr #(
  parameter int unsigned W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q
);
  logic [W-1:0] q_d;

  generate
    for (genvar i = 0; i < W; i++) begin : g_bit
      always_comb begin
        q_d[i] = q[i];
        if (en) begin
          if (set_i[i] && !clr_i[i])      q_d[i] = 1'b1;
          else if (clr_i[i] && !set_i[i]) q_d[i] = 1'b0;
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_d;
  end
endmodule

// File: rtl/irq_pend.sv
module irq_pend #(
  parameter int unsigned N = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-2:0] ack_i,
  input  logic         top_clr_i,
  output logic [N-1:0] q
);
  logic [N-1:0] clr_v;
  logic [N-1:0] q_d;

  assign clr_v = {top_clr_i, ack_i};

  always_comb begin
    q_d = set_i | (q & ~clr_v);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_d;
  end
endmodule

// File: rtl/irq_agg_top.sv
module irq_agg_top
  import irq_agg_pkg::*;
#(
  parameter int unsigned ADDR_W       = 4,
  parameter logic [31:0] VERSION_WORD = 32'h0202_0102
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_we,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic [5:0]        src_set,
  input  logic [4:0]        src_ack,
  output logic              irq_o
);
  localparam int unsigned HI_W = ADDR_W - 4;

  logic                 rst_sync_n;
  logic                 hit;
  logic [1:0]           idx;
  logic                 wr_ctrl;
  logic                 wr_mask;
  logic [NUM_SRC-1:0]   pend_q;
  logic [NUM_SRC-1:0]   mask_q;
  logic [NUM_SRC-1:0]   mask_set;
  logic [NUM_SRC-1:0]   mask_clr;
  logic [NUM_FLG-1:0]   flg_q;
  logic [NUM_FLG-1:0]   flg_set;
  logic [NUM_FLG-1:0]   flg_clr;
  logic [LEN_W-1:0]     len_q;
  logic [LEN_W-1:0]     len_d;
  logic                 irq_d;
  ctrl_view_t           ctrl_rd;

  irq_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  // address decode: word aligned, upper bits zero
  generate
    if (HI_W > 0) begin : g_hi
      assign hit = (reg_addr[1:0] == 2'b00) && (reg_addr[ADDR_W-1:4] == '0);
    end else begin : g_nohi
      assign hit = (reg_addr[1:0] == 2'b00);
    end
  endgenerate

  assign idx     = reg_addr[3:2];
  assign wr_ctrl = reg_we && hit && (idx == IDX_CTRL);
  assign wr_mask = reg_we && hit && (idx == IDX_MASK);

  // enable mask: bit 2i clears, bit 2i+1 sets
  generate
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_mstrobe
      assign mask_clr[i] = reg_wdata[2*i];
      assign mask_set[i] = reg_wdata[2*i+1];
    end
  endgenerate

  irq_setclr #(.W(NUM_SRC)) u_mask (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .en    (wr_mask),
    .set_i (mask_set),
    .clr_i (mask_clr),
    .q     (mask_q)
  );

  // control flags A, B, C
  assign flg_set = {reg_wdata[CTL_C_SET], reg_wdata[CTL_B_SET], reg_wdata[CTL_A_SET]};
  assign flg_clr = {reg_wdata[CTL_C_CLR], reg_wdata[CTL_B_CLR], reg_wdata[CTL_A_CLR]};

  irq_setclr #(.W(NUM_FLG)) u_flags (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .en    (wr_ctrl),
    .set_i (flg_set),
    .clr_i (flg_clr),
    .q     (flg_q)
  );

  // length field, plain load on every control write
  always_comb begin
    len_d = len_q;
    if (wr_ctrl) len_d = reg_wdata[LEN_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) len_q <= '0;
    else             len_q <= len_d;
  end

  irq_pend #(.N(NUM_SRC)) u_pend (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .set_i     (src_set),
    .ack_i     (src_ack),
    .top_clr_i (wr_ctrl && reg_wdata[CTL_P5_CLR]),
    .q         (pend_q)
  );

  // registered interrupt line
  assign irq_d = |(pend_q & mask_q);

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) irq_o <= 1'b0;
    else             irq_o <= irq_d;
  end

  // read path
  assign ctrl_rd = '{flg_c: flg_q[2], flg_b: flg_q[1], flg_a: flg_q[0], len: len_q};

  always_comb begin
    reg_rdata = '0;
    if (hit) begin
      unique case (idx)
        IDX_CTRL: reg_rdata[$bits(ctrl_view_t)-1:0] = ctrl_rd;
        IDX_VER:  reg_rdata = VERSION_WORD;
        IDX_PEND: reg_rdata[NUM_SRC-1:0] = pend_q;
        IDX_MASK: reg_rdata[NUM_SRC-1:0] = mask_q;
        default:  reg_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/irq_agg_chk.sv
module irq_agg_chk #(
  parameter int unsigned ADDR_W       = 4,
  parameter logic [31:0] VERSION_WORD = 32'h0202_0102
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              reg_we,
  input logic [31:0]       reg_wdata,
  input logic [31:0]       reg_rdata,
  input logic [5:0]        src_set,
  input logic [4:0]        src_ack,
  input logic [5:0]        pend_q,
  input logic [5:0]        mask_q,
  input logic              irq_o
);
  logic ctrl_wr;
  logic mask_wr;
  assign ctrl_wr = reg_we && (reg_addr == ADDR_W'(0));
  assign mask_wr = reg_we && (reg_addr == ADDR_W'(12));

  AST_IRQ_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == $past(|(pend_q & mask_q))) else $error("irq delay"); // R10

  AST_PEND_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (src_set != 6'd0) |=> ((pend_q & $past(src_set)) == $past(src_set))) else $error("pend set"); // R3

  AST_PEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (src_set == 6'd0 && src_ack == 5'd0 && !(ctrl_wr && reg_wdata[11])) |=> $stable(pend_q)) else $error("pend hold"); // R5

  AST_P5_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q[5] && !(ctrl_wr && reg_wdata[11])) |=> pend_q[5]) else $error("p5 clear"); // R4

  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !mask_wr |=> $stable(mask_q)) else $error("mask hold"); // R6

  AST_VER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == ADDR_W'(4)) |-> (reg_rdata == VERSION_WORD)) else $error("ver read"); // R2

  AST_PEND_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == ADDR_W'(8)) |-> (reg_rdata[31:6] == 26'd0)) else $error("pend upper"); // R5

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr[1:0] != 2'b00) |-> (reg_rdata == 32'd0)) else $error("unmapped"); // R11
endmodule

bind irq_agg_top irq_agg_chk #(.ADDR_W(ADDR_W), .VERSION_WORD(VERSION_WORD)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .reg_addr  (reg_addr),
  .reg_we    (reg_we),
  .reg_wdata (reg_wdata),
  .reg_rdata (reg_rdata),
  .src_set   (src_set),
  .src_ack   (src_ack),
  .pend_q    (pend_q),
  .mask_q    (mask_q),
  .irq_o     (irq_o)
);

// File: tb/sim_irq_agg_top.sv
module sim_irq_agg_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] VER = 32'h0202_0102;

  logic        clk;
  logic        rst_n;
  logic [3:0]  reg_addr;
  logic        reg_we;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic [5:0]  src_set;
  logic [4:0]  src_ack;
  logic        irq_o;

  int n_chk;
  int n_bad;

  // bench model
  logic [5:0] m_pend;
  logic [5:0] m_mask;
  logic [6:0] m_len;
  logic       m_a, m_b, m_c;

  irq_agg_top #(.ADDR_W(4), .VERSION_WORD(VER)) u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_addr  (reg_addr),
    .reg_we    (reg_we),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .src_set   (src_set),
    .src_ack   (src_ack),
    .irq_o     (irq_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic pair(logic q, logic s, logic c);
    if (s && !c) return 1'b1;
    if (c && !s) return 1'b0;
    return q;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(logic [3:0] a, logic [31:0] exp, string req);
    reg_addr = a;
    #1;
    check(req, reg_rdata, exp);
  endtask

  function automatic logic [31:0] ctrl_exp();
    return {22'd0, m_c, m_b, m_a, m_len};
  endfunction

  // one clock step; checks irq delay (R10)
  task automatic step();
    logic e_irq;
    e_irq = |(m_pend & m_mask);
    @(posedge clk);
    @(negedge clk);
    reg_we  = 1'b0;
    src_set = '0;
    src_ack = '0;
    check("R10 irq", {31'd0, irq_o}, {31'd0, e_irq});
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    logic [5:0] nset;
    reg_addr  = a;
    reg_wdata = d;
    reg_we    = 1'b1;
    nset      = src_set;
    if (a == 4'h0) begin
      m_len = d[6:0];
      m_a   = pair(m_a, d[8], d[7]);
      m_b   = pair(m_b, d[10], d[9]);
      m_c   = pair(m_c, d[13], d[12]);
    end
    if (a == 4'hC)
      for (int i = 0; i < 6; i++) m_mask[i] = pair(m_mask[i], d[2*i+1], d[2*i]);
    step_pend(nset, src_ack, (a == 4'h0) && d[11]);
  endtask

  task automatic step_pend(logic [5:0] s, logic [4:0] k, logic p5clr);
    logic [5:0] nxt;
    logic e_irq;
    e_irq = |(m_pend & m_mask);
    nxt   = s | (m_pend & ~{p5clr, k});
    @(posedge clk);
    m_pend = nxt;
    @(negedge clk);
    reg_we  = 1'b0;
    src_set = '0;
    src_ack = '0;
    check("R10 irq", {31'd0, irq_o}, {31'd0, e_irq});
  endtask

  task automatic pulse(logic [5:0] s, logic [4:0] k);
    src_set = s;
    src_ack = k;
    step_pend(s, k, 1'b0);
  endtask

  task automatic read_all(string req);
    rd(4'h0, ctrl_exp(), req);
    rd(4'h4, VER, req);
    rd(4'h8, {26'd0, m_pend}, req);
    rd(4'hC, {26'd0, m_mask}, req);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    n_chk = 0; n_bad = 0;
    rst_n = 1'b0; reg_addr = '0; reg_we = 1'b0; reg_wdata = '0;
    src_set = '0; src_ack = '0;
    m_pend = '0; m_mask = '0; m_len = '0; m_a = 0; m_b = 0; m_c = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    read_all("R1 reset");
    check("R1 irq reset", {31'd0, irq_o}, 32'd0);
    rd(4'h4, VER, "R2 version");

    // R6 / R7: exhaustive mask strobe sweep
    for (int p = 0; p < 4096; p++) begin
      wr(4'hC, 32'(p) | 32'hFFFF_F000);
      rd(4'hC, {26'd0, m_mask}, "R6 R7 mask");
    end

    // R8 / R9 / R7: control strobe sweep over bits 13:7 (bit 11 excluded later)
    for (int p = 0; p < 128; p++) begin
      wr(4'h0, {18'd0, 7'(p), 7'((p * 37 + 5) & 127)});
      rd(4'h0, ctrl_exp(), "R8 R9 ctrl");
    end

    // R3 / R10: every set/ack combination, two masks
    wr(4'hC, 32'h0000_0E67);
    for (int s = 0; s < 64; s++)
      for (int k = 0; k < 32; k++) begin
        pulse(6'(s), 5'(k));
        rd(4'h8, {26'd0, m_pend}, "R3 pend");
      end
    wr(4'hC, 32'h0000_0AAA);
    for (int s = 0; s < 64; s += 5)
      for (int k = 0; k < 32; k += 3) begin
        pulse(6'(s), 5'(k));
        rd(4'h8, {26'd0, m_pend}, "R3 pend mask2");
      end

    // R4: source 5 ignores acks, cleared by control bit 11, set wins
    pulse(6'h20, 5'h00);
    pulse(6'h00, 5'h1F);
    rd(4'h8, {26'd0, m_pend}, "R4 p5 survives ack");
    check("R4 p5 after ack", {31'd0, m_pend[5]}, 32'd1);
    src_set = 6'h20;
    wr(4'h0, 32'h0000_0800);
    rd(4'h8, {26'd0, m_pend}, "R4 set wins");
    check("R4 set wins bit", {31'd0, m_pend[5]}, 32'd1);
    wr(4'h0, 32'h0000_0800);
    rd(4'h8, {26'd0, m_pend}, "R4 clear");
    check("R4 cleared bit", {31'd0, m_pend[5]}, 32'd0);

    // R5 / R2: read-only words ignore writes
    pulse(6'h15, 5'h00);
    wr(4'h8, 32'hFFFF_FFFF);
    wr(4'h4, 32'hFFFF_FFFF);
    read_all("R5 R2 ro write");

    // R11: unmapped offsets
    for (int a = 0; a < 16; a++) begin
      if (a[1:0] != 2'b00) begin
        wr(4'(a), 32'hFFFF_FFFF);
        rd(4'(a), 32'd0, "R11 unmapped read");
      end
    end
    read_all("R11 no side effect");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule